// File: doc/BRIEF.md
# Cascaded Prescaler Reload Down-Timer

This block is a programmable interval timer. An 8-bit prescaler counts down on each count-source pulse. Each prescaler underflow steps an 8-bit primary counter down by one. Each stage reloads from its own reload register when it underflows, so a primary underflow occurs once every (n+1)(m+1) source pulses, where n is the prescaler reload value and m is the primary reload value. Each primary underflow sets a sticky interrupt-request flag.

The count source is one of four choices:
- the system clock itself;
- the system clock divided by two;
- the system clock divided by eight;
- rising edges of an underflow strobe from a neighbouring timer.

Every source is turned into a one-cycle enable inside the system clock domain, so no derived clock is ever formed.

Software reaches the block through a small register port with four addresses: control, prescaler, primary and flag. A write to a count register while the timer is stopped takes effect at once. A write made while the timer runs follows the write-mode bit. It either enters a short pipeline paced by count-source pulses, or it updates only the reload register.

Top module: `rld_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the prescaler (address 1) and primary (address 2) read 0xFF, and the flag (address 3, bit 0) and `irq` are 0.
- R2: While the run bit (control bit 0) is 0, a write to address 1 or 2 loads that stage's reload register and counter at once, and the counters do not change on their own.
- R3: With source select (control bits 3:2) = 0, a running prescaler steps down by one every clock cycle and reloads its reload value on the step after reading 0.
- R4: The primary counter steps down once per prescaler underflow and reloads on its own underflow, and each primary underflow sets `irq`. The interval between underflows is (n+1)(m+1) source pulses.
- R5: Source select 1 yields one count pulse per two clock cycles, and select 2 yields one per eight.
- R6: Source select 3 yields one count pulse per rising edge of `ext_uf`. A level held high counts only once.
- R7: A count-register write made while running with the write-mode bit (control bit 1) = 0 does four things. It sets `irq` at once. The next pulse copies the written value into the reload register. The second pulse loads the counters from their reload registers. Counting resumes with the third pulse.
- R8: A count-register write made while running with the write-mode bit = 1 changes only the reload register. The counter keeps counting and takes the new value at its next underflow, and the write does not set `irq`.
- R9: `irq` stays set until a write of bit 0 = 0 to address 3. Writing 1 there has no effect, and a hardware set in the same cycle as such a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 prescaler, 2 primary, 3 flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`; count registers return the live count |
| ext_uf | input | 1 | Underflow strobe from a neighbouring timer |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench measures the underflow interval for several reload pairs, including n = m = 0. In that case `irq` must stay set even across a clear, and an off-by-one reload shows up as a wrong interval. It follows the running write pipeline one pulse at a time, so a design that loads the counter a pulse early or a pulse late, or keeps counting during the transfer, returns the wrong value at a specific read. In write-mode 1 it checks that the counter is not disturbed and that no spurious interrupt appears. It also holds the external strobe high for several cycles, so a level-sensitive design would count more than once.

// File: rtl/rld_timer.sv
module rld_timer #(
  parameter int W        = 8,
  parameter int SLOW_DIV = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         ext_uf,
  output logic         irq
);
  localparam int DW = $clog2(SLOW_DIV);
  localparam logic [1:0] A_CTL = 2'd0, A_PRE = 2'd1, A_PRI = 2'd2, A_FLG = 2'd3;

  logic         run, wmode;
  logic [1:0]   src;
  logic [W-1:0] pre_cnt, pri_cnt, pre_rld, pri_rld, pre_hold, pri_hold;
  logic [DW-1:0] div;
  logic         ext_q;
  logic [1:0]   pend;
  logic         irq_q;
  logic         tick, wr_pre, wr_pri, wrreg, start_pipe, count, step1, step2;
  logic         pre_uf, pri_uf, sw_clr;

  always_comb begin
    case (src)
      2'd0:    tick = 1'b1;
      2'd1:    tick = div[0];
      2'd2:    tick = &div;
      default: tick = ext_uf & ~ext_q;
    endcase
  end

  assign wr_pre     = wr_en && addr == A_PRE;
  assign wr_pri     = wr_en && addr == A_PRI;
  assign wrreg      = wr_pre || wr_pri;
  assign start_pipe = wrreg && run && !wmode;
  assign step1      = run && tick && pend == 2'd1 && !start_pipe;
  assign step2      = run && tick && pend == 2'd2 && !start_pipe;
  assign count      = run && tick && pend == 2'd0 && !start_pipe;
  assign pre_uf     = count && pre_cnt == '0;
  assign pri_uf     = pre_uf && pri_cnt == '0;
  assign sw_clr     = wr_en && addr == A_FLG && !wdata[0];
  assign irq        = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      wmode <= 1'b0;
      src   <= 2'd0;
      div   <= '0;
      ext_q <= 1'b0;
    end else begin
      div   <= div + 1'b1;
      ext_q <= ext_uf;
      if (wr_en && addr == A_CTL) begin
        run   <= wdata[0];
        wmode <= wdata[1];
        src   <= wdata[3:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 2'd0;
    else if (start_pipe) pend <= 2'd1;
    else if (step1) pend <= 2'd2;
    else if (step2) pend <= 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '1;
      pre_rld  <= '1;
      pre_hold <= '1;
    end else begin
      if (count) pre_cnt <= pre_uf ? pre_rld : pre_cnt - 1'b1;
      if (step1) pre_rld <= pre_hold;
      if (step2) pre_cnt <= pre_rld;
      if (wr_pre) begin
        pre_hold <= wdata;
        if (!run) begin
          pre_rld <= wdata;
          pre_cnt <= wdata;
        end else if (wmode) begin
          pre_rld <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_cnt  <= '1;
      pri_rld  <= '1;
      pri_hold <= '1;
    end else begin
      if (pre_uf) pri_cnt <= pri_uf ? pri_rld : pri_cnt - 1'b1;
      if (step1) pri_rld <= pri_hold;
      if (step2) pri_cnt <= pri_rld;
      if (wr_pri) begin
        pri_hold <= wdata;
        if (!run) begin
          pri_rld <= wdata;
          pri_cnt <= wdata;
        end else if (wmode) begin
          pri_rld <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (pri_uf || start_pipe) irq_q <= 1'b1;
    else if (sw_clr) irq_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = {{(W-4){1'b0}}, src, wmode, run};
      A_PRE:   rdata = pre_cnt;
      A_PRI:   rdata = pri_cnt;
      default: rdata = {{(W-1){1'b0}}, irq_q};
    endcase
  end
endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic         run,
  input logic         wmode,
  input logic [1:0]   pend,
  input logic         count,
  input logic         start_pipe,
  input logic [W-1:0] pre_cnt,
  input logic [W-1:0] pri_cnt,
  input logic         irq
);
  p_stop_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !run) |=> pre_cnt == $past(wdata));

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && addr == 2'd2)) |=> $stable(pri_cnt));

  p_pre_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count && pre_cnt != '0) |=> pre_cnt == $past(pre_cnt) - 1'b1);

  p_uf_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count && pre_cnt == '0 && pri_cnt == '0) |=> irq);

  p_pipe_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pipe |=> (irq && pend == 2'd1));

  p_pipe_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pend == 2'd1) |=> $stable(pri_cnt));

  p_wm1_nopipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 2'd1 || addr == 2'd2) && run && wmode && pend == 2'd0) |=> pend == 2'd0);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == 2'd3 && !wdata[0])) |=> irq);
endmodule

bind rld_timer rld_timer_chk #(.W(W)) u_chk (.*);

// File: tb/rld_timer_bench.sv
`timescale 1ns/1ps
module rld_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_uf = 1'b0;
  logic       irq;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rld_timer u_rld_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_uf(ext_uf), .irq(irq)
  );

  // {n, m, expected interval}
  localparam logic [31:0] VEC [0:4] = '{
    32'h0000_0001, 32'h0102_0006, 32'h0300_0004, 32'h0204_000F, 32'h0403_0014
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 2000 && !irq; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, a, b, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); chk("R1 control", v, 0);
    rd(2'd1, v); chk("R1 prescaler", v, 255);
    rd(2'd2, v); chk("R1 primary", v, 255);
    rd(2'd3, v); chk("R1 flag", v, 0);
    chk("R1 irq", int'(irq), 0);

    for (int i = 0; i < 5; i++) begin
      wr(2'd0, 8'h00);
      wr(2'd1, VEC[i][31:24]);
      wr(2'd2, VEC[i][23:16]);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h01);
      wait_irq();
      wr(2'd3, 8'h00);
      p = 1;
      while (!irq && p < 2000) begin
        @(negedge clk);
        p++;
      end
      chk($sformatf("R4 interval n=%0d m=%0d", VEC[i][31:24], VEC[i][23:16]), p, int'(VEC[i][15:0]));
    end

    // R2 stopped write
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd5);
    wr(2'd2, 8'd40);
    rd(2'd1, v); chk("R2 immediate load", v, 5);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R2 stopped prescaler", v, 5);
    rd(2'd2, v); chk("R2 stopped primary", v, 40);

    // R3 divide-by-one stepping
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd9);
    wr(2'd0, 8'h01);
    rd(2'd1, v); chk("R3 start value", v, 3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rd(2'd1, v); chk("R3 step", v, (k == 3) ? 3 : 2 - k);
    end
    rd(2'd2, v); chk("R4 primary step", v, 8);

    // R5 slower sources
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd200);
    wr(2'd0, 8'h05);
    rd(2'd1, a);
    repeat (16) @(negedge clk);
    rd(2'd1, b); chk("R5 div2 pulses", a - b, 8);
    wr(2'd0, 8'h09);
    rd(2'd1, a);
    repeat (16) @(negedge clk);
    rd(2'd1, b); chk("R5 div8 pulses", a - b, 2);

    // R6 external strobe
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd10);
    wr(2'd0, 8'h0D);
    ext_uf = 1'b1;
    repeat (3) @(negedge clk);
    ext_uf = 1'b0;
    @(negedge clk);
    rd(2'd1, v); chk("R6 held level", v, 9);
    for (int k = 0; k < 2; k++) begin
      ext_uf = 1'b1; @(negedge clk);
      ext_uf = 1'b0; @(negedge clk);
    end
    rd(2'd1, v); chk("R6 two edges", v, 7);

    // R7 running write, write-mode 0
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd50);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h01);
    repeat (3) @(negedge clk);
    wr(2'd2, 8'd7);
    chk("R7 irq on write", int'(irq), 1);
    rd(2'd2, a);
    @(negedge clk);
    rd(2'd2, v); chk("R7 first pulse holds", v, a);
    @(negedge clk);
    rd(2'd2, v); chk("R7 second pulse loads", v, 7);
    @(negedge clk);
    rd(2'd2, v); chk("R7 third pulse counts", v, 6);

    // R8 running write, write-mode 1
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd3);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'd5);
    rd(2'd2, v); chk("R8 counter undisturbed", v, 2);
    chk("R8 no irq from write", int'(irq), 0);
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R8 reaches zero", v, 0);
    @(negedge clk);
    rd(2'd2, v); chk("R8 new reload used", v, 5);
    chk("R8 irq on underflow", int'(irq), 1);

    // R9 sticky flag
    wr(2'd0, 8'h00);
    repeat (4) @(negedge clk);
    chk("R9 sticky", int'(irq), 1);
    wr(2'd3, 8'h01);
    chk("R9 write one ignored", int'(irq), 1);
    wr(2'd3, 8'h00);
    chk("R9 clear", int'(irq), 0);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h01);
    @(negedge clk);
    wr(2'd3, 8'h00);
    chk("R9 set wins over clear", int'(irq), 1);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    chk("R9 clear after stop", int'(irq), 0);

    finish_run();
  end
endmodule